// File: doc/BRIEF.md
# Word Load/Store Address Generator with Base Writeback

This block forms the effective byte address of a single 32-bit word load or store and the updated base value for the base register. An operation carries a base value, an offset source and an addressing mode. The offset is either a zero-extended immediate byte count or an index value shifted left by a 5-bit amount. Three modes are supported:

- **Offset:** accesses base plus offset and leaves the base register unchanged.
- **Pre-indexed:** accesses base plus offset and writes that same sum back to the base register.
- **Post-indexed:** accesses the unmodified base and writes base plus offset back to the base register.

All address arithmetic wraps modulo 2^32.

Accepted operations become requests on a word-memory port. A request is held until the memory signals ready. The base writeback is then reported as a one-cycle strobe, and for loads the returned word is forwarded with a load-done strobe. An access address that is not a multiple of 4 is refused: no memory request is made, no writeback is made, and a one-cycle error pulse is raised instead. The register file, the instruction decoder and any cache sit outside this block.

Top module: `ldst_agu`

## Requirements
- R1: With `op_mode` 0 (offset) or 3, the memory address is base plus offset and `wb_en` stays low for the whole operation.
- R2: With `op_mode` 1 (pre-indexed), the memory address is base plus offset and `wb_en` pulses with `wb_value` equal to that same sum.
- R3: With `op_mode` 2 (post-indexed), the memory address is the unmodified base and `wb_en` pulses with `wb_value` equal to base plus offset.
- R4: When `op_use_reg` is 0, the offset is `op_imm` zero-extended to 32 bits. When `op_use_reg` is 1, the offset is `op_index` shifted left by `op_shamt` (0 to 31), and a shift of 0 uses `op_index` unchanged.
- R5: If the access address has bit 1 or bit 0 set, no memory request is made and no writeback is made, and `misalign_err` is high for exactly the one cycle after acceptance. Only the access address is checked; a misaligned writeback value is allowed.
- R6: Both the sum and the shifted index wrap modulo 2^32, and no overflow indication exists.
- R7: A store (`op_store`=1) follows the same address and writeback rules as a load. It drives `mem_write`=1 and `mem_wdata`=`op_wdata`, and never raises `ld_done`.
- R8: An operation is accepted on a clock edge where `op_valid` and `op_ready` are both high. `mem_valid` rises in the next cycle, and `mem_valid`, `mem_addr`, `mem_write` and `mem_wdata` stay constant until an edge with `mem_ready` high. `op_ready` is low while a request is outstanding.
- R9: In the cycle after the edge where `mem_valid` and `mem_ready` are both high, `mem_valid` is low. In that same cycle, `wb_en` reports the writeback, and for a load `ld_done` pulses for one cycle with `ld_data` equal to the `mem_rdata` seen on that edge.
- R10: After a synchronous reset, `op_ready` is high and `mem_valid`, `wb_en`, `ld_done` and `misalign_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation present |
| op_ready | output | 1 | Block can accept an operation |
| op_store | input | 1 | 1 = store, 0 = load |
| op_mode | input | 2 | 0 offset, 1 pre-indexed, 2 post-indexed, 3 treated as offset |
| op_use_reg | input | 1 | Offset source: 0 immediate, 1 shifted index |
| op_base | input | 32 | Base register value |
| op_index | input | 32 | Index register value |
| op_shamt | input | 5 | Left shift applied to the index |
| op_imm | input | 12 | Immediate byte offset |
| op_wdata | input | 32 | Store data |
| mem_valid | output | 1 | Memory request pending |
| mem_ready | input | 1 | Memory accepts the request |
| mem_write | output | 1 | Request is a write |
| mem_addr | output | 32 | Request byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| ld_done | output | 1 | Load data returned |
| ld_data | output | 32 | Returned load word |
| wb_en | output | 1 | Base register write strobe |
| wb_value | output | 32 | New base value |
| misalign_err | output | 1 | Misaligned access refused |

## Verification
The request appears on the memory port one cycle after the accepting edge. A misalignment pulse appears in that same cycle instead. The writeback and load-done strobes appear one cycle after the edge that carries `mem_ready`. The bench drives every input at the falling edge and samples at the next falling edge, so each observation falls exactly one register stage after its cause. The bench also checks the cycle that follows each strobe to confirm that it lasts a single cycle. Memory readiness is withheld for a varying number of cycles, and each withheld cycle is checked for a held, unchanged request.

// File: rtl/ldst_pkg.sv
package ldst_pkg;

    parameter int AW         = 32;
    parameter int DW         = 32;
    parameter int IMM_W      = 12;
    parameter int SHAMT_W    = 5;
    parameter int ALIGN_BITS = 2;

    typedef enum logic [1:0] {
        AM_OFFSET = 2'd0,
        AM_PRE    = 2'd1,
        AM_POST   = 2'd2,
        AM_RSVD   = 2'd3
    } amode_e;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [AW-1:0] new_base;
        logic          wb_req;
        logic          misaligned;
    } addr_res_t;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic          write;
        logic          wb_req;
        logic [AW-1:0] wb_value;
    } mem_req_t;

    function automatic logic low_bits_set(input logic [AW-1:0] a);
        return |a[ALIGN_BITS-1:0];
    endfunction

endpackage

// File: rtl/ldst_offset_gen.sv
module ldst_offset_gen
    import ldst_pkg::*;
#(
    parameter int OW   = DW,
    parameter int IW   = IMM_W,
    parameter int SW   = SHAMT_W
) (
    input  logic          use_reg,
    input  logic [IW-1:0] imm,
    input  logic [OW-1:0] index,
    input  logic [SW-1:0] shamt,
    output logic [OW-1:0] offset
);
    logic [OW-1:0] shifted;

    always_comb begin
        shifted = index << shamt;
        offset  = use_reg ? shifted : OW'(imm);
    end

endmodule

// File: rtl/ldst_addr_sel.sv
module ldst_addr_sel
    import ldst_pkg::*;
(
    input  logic [1:0]    mode,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] offset,
    output addr_res_t     res
);
    logic [AW-1:0] sum;

    always_comb begin
        sum          = base + offset;
        res.new_base = sum;
        case (amode_e'(mode))
            AM_PRE: begin
                res.addr   = sum;
                res.wb_req = 1'b1;
            end
            AM_POST: begin
                res.addr   = base;
                res.wb_req = 1'b1;
            end
            default: begin
                res.addr   = sum;
                res.wb_req = 1'b0;
            end
        endcase
        res.misaligned = low_bits_set(res.addr);
    end

endmodule

// File: rtl/ldst_req_ctrl.sv
module ldst_req_ctrl
    import ldst_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          op_valid,
    output logic          op_ready,
    input  logic          op_store,
    input  logic [DW-1:0] op_wdata,
    input  addr_res_t     res,
    output logic          mem_valid,
    input  logic          mem_ready,
    output logic          mem_write,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic          ld_done,
    output logic [DW-1:0] ld_data,
    output logic          wb_en,
    output logic [AW-1:0] wb_value,
    output logic          misalign_err
);
    typedef enum logic {ST_IDLE, ST_BUSY} state_e;

    state_e   state;
    mem_req_t req_q;
    logic     accept;

    assign accept    = op_valid && (state == ST_IDLE);
    assign op_ready  = (state == ST_IDLE);
    assign mem_valid = (state == ST_BUSY);
    assign mem_write = req_q.write;
    assign mem_addr  = req_q.addr;
    assign mem_wdata = req_q.wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= ST_IDLE;
            req_q        <= '0;
            ld_done      <= 1'b0;
            ld_data      <= '0;
            wb_en        <= 1'b0;
            wb_value     <= '0;
            misalign_err <= 1'b0;
        end else begin
            ld_done      <= 1'b0;
            wb_en        <= 1'b0;
            misalign_err <= 1'b0;
            if (accept) begin
                if (res.misaligned) begin
                    misalign_err <= 1'b1;
                end else begin
                    state          <= ST_BUSY;
                    req_q.addr     <= res.addr;
                    req_q.wdata    <= op_wdata;
                    req_q.write    <= op_store;
                    req_q.wb_req   <= res.wb_req;
                    req_q.wb_value <= res.new_base;
                end
            end else if (state == ST_BUSY && mem_ready) begin
                state    <= ST_IDLE;
                wb_en    <= req_q.wb_req;
                wb_value <= req_q.wb_value;
                if (!req_q.write) begin
                    ld_done <= 1'b1;
                    ld_data <= mem_rdata;
                end
            end
        end
    end

    // R8
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)
                                      && $stable(mem_write) && $stable(mem_wdata)));

    // R5
    aligned_req_chk: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> (mem_addr[1:0] == 2'b00));

    // R9
    strobe_after_hs_chk: assert property (@(posedge clk) disable iff (rst)
        (wb_en || ld_done) |-> $past(mem_valid && mem_ready));

    // R7
    no_store_done_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && mem_ready && mem_write) |=> !ld_done);

endmodule

// File: rtl/ldst_agu.sv
module ldst_agu
    import ldst_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               op_valid,
    output logic               op_ready,
    input  logic               op_store,
    input  logic [1:0]         op_mode,
    input  logic               op_use_reg,
    input  logic [AW-1:0]      op_base,
    input  logic [DW-1:0]      op_index,
    input  logic [SHAMT_W-1:0] op_shamt,
    input  logic [IMM_W-1:0]   op_imm,
    input  logic [DW-1:0]      op_wdata,
    output logic               mem_valid,
    input  logic               mem_ready,
    output logic               mem_write,
    output logic [AW-1:0]      mem_addr,
    output logic [DW-1:0]      mem_wdata,
    input  logic [DW-1:0]      mem_rdata,
    output logic               ld_done,
    output logic [DW-1:0]      ld_data,
    output logic               wb_en,
    output logic [AW-1:0]      wb_value,
    output logic               misalign_err
);
    logic [AW-1:0] offset;
    addr_res_t     res;

    ldst_offset_gen #(.OW(AW), .IW(IMM_W), .SW(SHAMT_W)) u_ofs (
        .use_reg (op_use_reg),
        .imm     (op_imm),
        .index   (op_index),
        .shamt   (op_shamt),
        .offset  (offset)
    );

    ldst_addr_sel u_sel (
        .mode   (op_mode),
        .base   (op_base),
        .offset (offset),
        .res    (res)
    );

    ldst_req_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .op_valid     (op_valid),
        .op_ready     (op_ready),
        .op_store     (op_store),
        .op_wdata     (op_wdata),
        .res          (res),
        .mem_valid    (mem_valid),
        .mem_ready    (mem_ready),
        .mem_write    (mem_write),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .mem_rdata    (mem_rdata),
        .ld_done      (ld_done),
        .ld_data      (ld_data),
        .wb_en        (wb_en),
        .wb_value     (wb_value),
        .misalign_err (misalign_err)
    );

    // R5
    err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        misalign_err |-> (!mem_valid && !wb_en && !ld_done));

    // R10
    reset_idle_chk: assert property (@(posedge clk)
        $past(rst) |-> (op_ready && !mem_valid && !wb_en && !ld_done && !misalign_err));

endmodule

// File: tb/tb_ldst_agu.sv
`timescale 1ns/1ps
module tb_ldst_agu;
    import ldst_pkg::*;

    logic        clk = 1'b0;
    logic        rst;
    logic        op_valid, op_ready, op_store, op_use_reg;
    logic [1:0]  op_mode;
    logic [31:0] op_base, op_index, op_wdata;
    logic [4:0]  op_shamt;
    logic [11:0] op_imm;
    logic        mem_valid, mem_ready, mem_write;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        ld_done, wb_en, misalign_err;
    logic [31:0] ld_data, wb_value;

    int n_run  = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    ldst_agu dut (.*);

    typedef struct packed {
        logic [1:0]  mode;
        logic        use_reg;
        logic        store;
        logic [31:0] base;
        logic [31:0] index;
        logic [4:0]  shamt;
        logic [11:0] imm;
        logic [31:0] exp_addr;
        logic        exp_wb;
        logic [31:0] exp_wbv;
        logic        exp_mis;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        // R1 R4 offset, immediate
        '{2'd0, 1'b0, 1'b0, 32'h0000_1000, 32'h0, 5'd0, 12'h008, 32'h0000_1008, 1'b0, 32'h0, 1'b0},
        // R2 R4 pre, index shift 0
        '{2'd1, 1'b1, 1'b0, 32'h0000_2000, 32'h4, 5'd0, 12'h000, 32'h0000_2004, 1'b1, 32'h0000_2004, 1'b0},
        // R3 R7 post store, index<<2
        '{2'd2, 1'b1, 1'b1, 32'h0000_3000, 32'h3, 5'd2, 12'h000, 32'h0000_3000, 1'b1, 32'h0000_300C, 1'b0},
        // R5 pre misaligned sum
        '{2'd1, 1'b0, 1'b1, 32'h4000_0000, 32'h0, 5'd0, 12'h012, 32'h0, 1'b0, 32'h0, 1'b1},
        // R5 post misaligned base
        '{2'd2, 1'b0, 1'b0, 32'h4000_0002, 32'h0, 5'd0, 12'h002, 32'h0, 1'b0, 32'h0, 1'b1},
        // R5 R3 post aligned base, misaligned writeback allowed
        '{2'd2, 1'b0, 1'b0, 32'h4000_0000, 32'h0, 5'd0, 12'h002, 32'h4000_0000, 1'b1, 32'h4000_0002, 1'b0},
        // R6 wrap
        '{2'd0, 1'b1, 1'b0, 32'hFFFF_FFF0, 32'h20, 5'd0, 12'h000, 32'h0000_0010, 1'b0, 32'h0, 1'b0},
        // R4 R2 shift 31
        '{2'd1, 1'b1, 1'b1, 32'h0000_0100, 32'h1, 5'd31, 12'h000, 32'h8000_0100, 1'b1, 32'h8000_0100, 1'b0},
        // R1 mode 3 as offset
        '{2'd3, 1'b0, 1'b0, 32'h0000_0500, 32'h0, 5'd0, 12'h004, 32'h0000_0504, 1'b0, 32'h0, 1'b0},
        // R6 shifted index wraps
        '{2'd0, 1'b1, 1'b1, 32'h0000_0010, 32'hFFFF_FFFF, 5'd2, 12'h000, 32'h0000_000C, 1'b0, 32'h0, 1'b0}
    };

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v, input int delay, input logic [31:0] rdata, input logic [31:0] wdata);
        @(negedge clk);
        op_valid = 1'b1; op_mode = v.mode; op_use_reg = v.use_reg; op_store = v.store;
        op_base = v.base; op_index = v.index; op_shamt = v.shamt; op_imm = v.imm; op_wdata = wdata;
        @(negedge clk);
        op_valid = 1'b0;
        if (v.exp_mis) begin
            chk(misalign_err === 1'b1, "R5 err pulse", 32'(misalign_err), 32'd1);
            chk(mem_valid === 1'b0, "R5 no request", 32'(mem_valid), 32'd0);
            @(negedge clk);
            chk(misalign_err === 1'b0, "R5 err one cycle", 32'(misalign_err), 32'd0);
            chk(wb_en === 1'b0 && mem_valid === 1'b0, "R5 no writeback", 32'(wb_en), 32'd0);
            return;
        end
        chk(mem_valid === 1'b1, "R8 request raised", 32'(mem_valid), 32'd1);
        chk(op_ready === 1'b0, "R8 busy", 32'(op_ready), 32'd0);
        chk(mem_addr === v.exp_addr, "R1 R2 R3 address", mem_addr, v.exp_addr);
        chk(mem_write === v.store, "R7 write flag", 32'(mem_write), 32'(v.store));
        if (v.store) chk(mem_wdata === wdata, "R7 write data", mem_wdata, wdata);
        for (int i = 0; i < delay; i++) begin
            @(negedge clk);
            chk(mem_valid === 1'b1 && mem_addr === v.exp_addr, "R8 held", mem_addr, v.exp_addr);
        end
        mem_ready = 1'b1; mem_rdata = rdata;
        @(negedge clk);
        mem_ready = 1'b0; mem_rdata = 32'hDEAD_BEEF;
        chk(mem_valid === 1'b0, "R9 request dropped", 32'(mem_valid), 32'd0);
        chk(wb_en === v.exp_wb, "R1 R2 R3 wb_en", 32'(wb_en), 32'(v.exp_wb));
        if (v.exp_wb) chk(wb_value === v.exp_wbv, "R2 R3 R6 wb_value", wb_value, v.exp_wbv);
        chk(ld_done === !v.store, "R9 R7 ld_done", 32'(ld_done), 32'(!v.store));
        if (!v.store) chk(ld_data === rdata, "R9 ld_data", ld_data, rdata);
        @(negedge clk);
        chk(wb_en === 1'b0 && ld_done === 1'b0, "R9 single pulse", 32'(wb_en | ld_done), 32'd0);
        chk(op_ready === 1'b1, "R8 ready again", 32'(op_ready), 32'd1);
    endtask

    initial begin
        rst = 1'b1; op_valid = 1'b0; op_mode = 2'd0; op_use_reg = 1'b0; op_store = 1'b0;
        op_base = '0; op_index = '0; op_shamt = '0; op_imm = '0; op_wdata = '0;
        mem_ready = 1'b0; mem_rdata = '0;
        repeat (3) @(negedge clk);
        chk(op_ready === 1'b1 && mem_valid === 1'b0, "R10 reset idle", 32'(mem_valid), 32'd0);
        chk(wb_en === 1'b0 && ld_done === 1'b0 && misalign_err === 1'b0, "R10 strobes low",
            32'(wb_en | ld_done | misalign_err), 32'd0);
        rst = 1'b0;

        for (int k = 0; k < NV; k++)
            run_vec(VEC[k], k % 4, 32'hA500_0000 + 32'(k), 32'h5A00_0000 + 32'(k));

        // R8: long wait on a store with pre-index writeback
        run_vec(VEC[7], 9, 32'h0, 32'hCAFE_F00D);

        // R10: reset mid request drops it
        @(negedge clk);
        op_valid = 1'b1; op_mode = 2'd0; op_use_reg = 1'b0; op_base = 32'h100; op_imm = 12'h0;
        @(negedge clk);
        op_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(mem_valid === 1'b0 && op_ready === 1'b1, "R10 reset clears request", 32'(mem_valid), 32'd0);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule